// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link and turns it into parallel left and right words. The three wires are a bit clock, a frame clock and a data line. A fast system clock oversamples all three inputs through synchronizers. Each rising bit-clock edge becomes a one-cycle event, and the receiver counts these events from the last frame-clock transition to find where each word sits.

The framing format and the word width are static selectors. Four formats are supported:

- I2S
- left-justified
- right-justified
- a DSP-style format, where the frame clock toggles once per word and carries no channel identity

Words of 24, 20 or 16 bits are supported. Every captured word is left-aligned into a 24-bit output, with zeros in the unused low bits. A one-cycle strobe marks each completed left/right pair. The bit clock may stop between bits, because the position count advances only on bit-clock edges and not on system-clock time.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_ni` is low and after it is released, `left_o` and `right_o` are zero and `valid_o` is low until the first pair is delivered.
- R2: After reset is released, no pair is delivered until a rising frame-clock transition has been seen at a bit-clock rising edge. Words that complete before that transition are dropped. In I2S the right word of the arming frame has no left partner and is discarded.
- R3: In I2S (`fmt_i` = 2'b00), the MSB is sampled on the second bit-clock rise after a frame-clock transition, and frame clock low marks the left word.
- R4: In left-justified (`fmt_i` = 2'b11), the MSB is sampled on the first bit-clock rise after a frame-clock transition, and frame clock high marks the left word.
- R5: In right-justified (`fmt_i` = 2'b01), the word is the last N bits sampled before a frame-clock transition. It belongs to the channel of the slot that just ended, and frame clock high marks left.
- R6: In the DSP format (`fmt_i` = 2'b10), every frame-clock transition starts a word whose MSB comes on the second bit-clock rise. The first word after arming is left, and channels then alternate by arrival order.
- R7: The width select `wsel_i` maps 2'b00 to 24 bits, 2'b01 to 20 bits, and 2'b10 or 2'b11 to 16 bits. Data arrives MSB first in two's complement. The N-bit word appears in bits 23 down to 24-N of the output, and the lower bits are zero.
- R8: `valid_o` pulses for exactly one system clock after each right word that completes a pair. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R9: Data and frame clock are sampled only on bit-clock rising edges. Pauses of any length with the bit clock held low do not alter the captured words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Framing format select |
| wsel_i | input | 2 | Word width select |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Serial frame clock |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left word, left-aligned |
| right_o | output | 24 | Right word, left-aligned |
| valid_o | output | 1 | One-cycle pair strobe |

## Verification
The hardest condition to reach from the ports is the start-up window. This is the stretch after reset in which words complete before the receiver is armed, or complete on the wrong side of the arming transition. How it plays out differs per format.

Each vector is therefore run from a fresh reset, with the frame clock idling at the level opposite to its first slot. This makes the arming edge fall at a known place. The bench then counts the pair strobes per vector and compares the count against the number of pairs that should survive: two for I2S and right-justified, three otherwise.

The bench also drives a burst run in which the bit clock is held low for many cycles between bits. It separately drives a run with only falling frame-clock edges, which must produce no strobe.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int MAX_W = 24;
  localparam int NB_W  = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_DSP = 2'b10,
    FMT_LJ  = 2'b11
  } fmt_e;

  function automatic logic [NB_W-1:0] width_bits(input logic [1:0] wsel);
    case (wsel)
      2'b00:   width_bits = NB_W'(24);
      2'b01:   width_bits = NB_W'(20);
      default: width_bits = NB_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int SYNC_STAGES = 2  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic bit_evt_o,
  output logic lr_o,
  output logic dat_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] b_q, l_q, d_q;
  logic         b_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q <= '1;
      b_d <= 1'b1;
      l_q <= '0;
      d_q <= '0;
    end else begin
      b_q <= {b_q[TOP-1:0], bclk_i};
      l_q <= {l_q[TOP-1:0], lrclk_i};
      d_q <= {d_q[TOP-1:0], sdata_i};
      b_d <= b_q[TOP];
    end
  end

  assign bit_evt_o = b_q[TOP] & ~b_d;
  assign lr_o      = l_q[TOP];
  assign dat_o     = d_q[TOP];

  assert_one_evt_per_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_evt_o |=> !bit_evt_o);
endmodule

// File: rtl/sar_slot_ctrl.sv
module sar_slot_ctrl
  import sar_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_evt_i,
  input  logic            lr_i,
  input  fmt_e            fmt_i,
  input  logic [NB_W-1:0] nbits_i,
  output logic            shift_o,
  output logic            done_o,
  output logic            done_left_o,
  output logic            use_prev_o,
  output logic            armed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             seen_q, prev_lr_q, armed_q, dsp_left_q;
  logic [CNT_W-1:0] cnt_q, pos, nb;
  logic             lr_edge, lr_rise, dsp_left_d;
  logic             shift_raw, done_raw;

  assign nb = CNT_W'(nbits_i);

  always_comb begin
    lr_edge    = seen_q && (lr_i != prev_lr_q);
    lr_rise    = lr_edge && lr_i;
    pos        = lr_edge ? '0 : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1);
    dsp_left_d = lr_edge ? (armed_q ? ~dsp_left_q : 1'b1) : dsp_left_q;
    shift_raw   = 1'b0;
    done_raw    = 1'b0;
    done_left_o = 1'b0;
    use_prev_o  = 1'b0;
    case (fmt_i)
      FMT_LJ: begin
        shift_raw   = pos < nb;
        done_raw    = pos == nb - 1'b1;
        done_left_o = lr_i;
      end
      FMT_I2S: begin
        shift_raw   = (pos != '0) && (pos <= nb);
        done_raw    = pos == nb;
        done_left_o = ~lr_i;
      end
      FMT_DSP: begin
        shift_raw   = (pos != '0) && (pos <= nb);
        done_raw    = pos == nb;
        done_left_o = dsp_left_d;
      end
      FMT_RJ: begin
        shift_raw   = 1'b1;
        done_raw    = lr_edge;
        done_left_o = prev_lr_q;
        use_prev_o  = 1'b1;
      end
    endcase
    shift_o = bit_evt_i & shift_raw;
    done_o  = bit_evt_i & armed_q & done_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      prev_lr_q  <= 1'b0;
      armed_q    <= 1'b0;
      dsp_left_q <= 1'b0;
      cnt_q      <= '0;
    end else if (bit_evt_i) begin
      seen_q     <= 1'b1;
      prev_lr_q  <= lr_i;
      cnt_q      <= pos;
      dsp_left_q <= dsp_left_d;
      if (lr_rise) armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;

  assert_arm_on_rise_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !(bit_evt_i && lr_i && seen_q && !prev_lr_q)) |=> !armed_q);
endmodule

// File: rtl/sar_word_asm.sv
module sar_word_asm
  import sar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             dat_i,
  input  logic             use_prev_i,
  input  logic [NB_W-1:0]  nbits_i,
  output logic [MAX_W-1:0] word_o
);
  logic [MAX_W-1:0] sr_q, sr_next, src;

  assign sr_next = {sr_q[MAX_W-2:0], dat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= sr_next;
  end

  // right-justified takes the bits before the current edge; others include it
  assign src    = use_prev_i ? sr_q : sr_next;
  assign word_o = src << (NB_W'(MAX_W) - nbits_i);
endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out
  import sar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             done_left_i,
  input  logic [MAX_W-1:0] word_i,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             valid_o
);
  logic [MAX_W-1:0] left_hold_q;
  logic             have_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (done_left_i) begin
          left_hold_q <= word_i;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= left_hold_q;
          right_o     <= word_i;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((left_o != $past(left_o)) || (right_o != $past(right_o))) |-> valid_o);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  wsel_i,
  input  logic        bclk_i,
  input  logic        lrclk_i,
  input  logic        sdata_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  logic             bit_evt, lr_s, dat_s;
  logic             shift, done, done_left, use_prev, armed;
  logic [NB_W-1:0]  nbits;
  logic [MAX_W-1:0] word;
  fmt_e             fmt;

  assign fmt   = fmt_e'(fmt_i);
  assign nbits = width_bits(wsel_i);

  sar_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .sdata_i(sdata_i), .bit_evt_o(bit_evt), .lr_o(lr_s), .dat_o(dat_s));

  sar_slot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_evt_i(bit_evt), .lr_i(lr_s),
    .fmt_i(fmt), .nbits_i(nbits), .shift_o(shift), .done_o(done),
    .done_left_o(done_left), .use_prev_o(use_prev), .armed_o(armed));

  sar_word_asm u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift), .dat_i(dat_s),
    .use_prev_i(use_prev), .nbits_i(nbits), .word_o(word));

  sar_pair_out u_pair (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .done_left_i(done_left),
    .word_i(word), .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

  assert_no_valid_unarmed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !valid_o);
  assert_zero_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wsel_i[1]) |-> ((left_o[7:0] == 8'h00) && (right_o[7:0] == 8'h00)));
endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  localparam int HALF = 4;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt_i = 2'b00, wsel_i = 2'b00;
  logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int total = 0, fails = 0, vcnt = 0, dbl = 0;
  logic        prev_v = 1'b0;
  logic [23:0] cap_l = '0, cap_r = '0;

  always #10 clk = ~clk;

  serial_audio_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt_i), .wsel_i(wsel_i),
    .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

  // {fmt, wsel, left, right}; fmt 0=I2S 1=RJ 2=DSP 3=LJ
  localparam logic [51:0] VECS [NVEC] = '{
    {2'd0, 2'd0, 24'h123456, 24'hFEDCBA},
    {2'd0, 2'd1, 24'hABCDEF, 24'h13579B},
    {2'd0, 2'd2, 24'h8000FF, 24'h7FFF01},
    {2'd3, 2'd0, 24'h800001, 24'h7FFFFE},
    {2'd3, 2'd1, 24'h5A5A5A, 24'hA5A5A5},
    {2'd3, 2'd3, 24'hC3C3C3, 24'h3C3C3C},
    {2'd1, 2'd0, 24'hF0F0F0, 24'h0F0F0F},
    {2'd1, 2'd1, 24'hFFFFFF, 24'h000010},
    {2'd1, 2'd2, 24'hABCD12, 24'hDCBA34},
    {2'd2, 2'd0, 24'h112233, 24'h445566},
    {2'd2, 2'd1, 24'hFEDCBA, 24'h012345},
    {2'd2, 2'd2, 24'h9999AA, 24'h6666BB}
  };

  always @(negedge clk) begin
    if (valid_o) begin
      vcnt++;
      cap_l = left_o;
      cap_r = right_o;
      if (prev_v) dbl++;
    end
    prev_v = valid_o;
  end

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(input int w);
    return (w == 0) ? 24 : (w == 1) ? 20 : 16;
  endfunction

  function automatic logic slot_bit(input int fmt, input int n, input int p, input logic [23:0] w);
    if (fmt == 3) return (p < n) ? w[23-p] : 1'b0;
    if (fmt == 1) return (p >= 32 - n) ? w[23-(p-(32-n))] : 1'b0;
    return (p >= 1 && p <= n) ? w[24-p] : 1'b0;
  endfunction

  task automatic send_bit(input logic lr, input logic d, input int gap);
    @(negedge clk);
    bclk_i = 1'b0; lrclk_i = lr; sdata_i = d;
    repeat (HALF + gap) @(negedge clk);
    bclk_i = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_slot(input int fmt, input int n, input logic lr, input logic [23:0] w, input int gap);
    for (int p = 0; p < 32; p++) send_bit(lr, slot_bit(fmt, n, p, w), gap);
  endtask

  task automatic do_reset(input int fmt, input int wsel, input logic idle_lr);
    @(negedge clk);
    rst_ni = 1'b0; bclk_i = 1'b0; lrclk_i = idle_lr; sdata_i = 1'b0;
    fmt_i = 2'(fmt); wsel_i = 2'(wsel);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_vec(input int fmt, input int wsel, input logic [23:0] l,
                         input logic [23:0] r, input int gap, input string tag);
    int n, base, exp_cnt;
    logic first_lr;
    logic [23:0] mask;
    n        = nb_of(wsel);
    mask     = 24'hFFFFFF << (24 - n);
    first_lr = (fmt == 0) ? 1'b0 : 1'b1;
    do_reset(fmt, wsel, ~first_lr);
    base = vcnt;
    for (int k = 0; k < 4; k++) send_bit(~first_lr, 1'b0, gap);
    for (int f = 0; f < 3; f++) begin
      send_slot(fmt, n, first_lr, l, gap);
      send_slot(fmt, n, ~first_lr, r, gap);
    end
    repeat (10) @(negedge clk);
    exp_cnt = (fmt == 0 || fmt == 1) ? 2 : 3;
    check({tag, " left"},  cap_l, l & mask);
    check({tag, " right"}, cap_r, r & mask);
    check("R8 pair count", 24'(vcnt - base), 24'(exp_cnt));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    string tags [4] = '{"R3 i2s", "R5 rj", "R6 dsp", "R4 lj"};
    // R1: reset state
    do_reset(0, 0, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 left reset",  left_o, 24'h0);
    check("R1 right reset", right_o, 24'h0);
    check("R1 valid reset", 24'(valid_o), 24'h0);

    // R2: only a falling frame-clock edge, no arming, no strobe
    for (int k = 0; k < 4; k++) send_bit(1'b1, 1'b1, 0);
    send_slot(0, 24, 1'b0, 24'hFFFFFF, 0);
    send_slot(0, 24, 1'b0, 24'hFFFFFF, 0);
    repeat (10) @(negedge clk);
    check("R2 no strobe unarmed", 24'(vcnt), 24'h0);
    check("R2 outputs idle", left_o | right_o, 24'h0);

    // table: all formats and widths (R7 via masks)
    for (int i = 0; i < NVEC; i++) begin
      run_vec(int'(VECS[i][51:50]), int'(VECS[i][49:48]), VECS[i][47:24], VECS[i][23:0],
              0, {tags[VECS[i][51:50]], " R7"});
    end

    // R9: gated bit clock, long low pauses between bits
    run_vec(0, 0, 24'h6B2C91, 24'h94D36E, 11, "R9 gated i2s");
    run_vec(3, 1, 24'hE1F2A3, 24'h1E0D5C, 7, "R9 gated lj");

    check("R8 single-cycle strobe", 24'(dbl), 24'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule